// File: doc/BRIEF.md
# Four-Bit Function-Select ALU Slice with Ripple Chain

The block is a combinational arithmetic/logic slice that works on two 4-bit active-high operands. A 4-bit select code and a mode bit pick one of 32 operations. With the mode bit high, the slice computes one of the 16 two-input Boolean functions independently on each bit position. With the mode bit low, it computes one of 16 arithmetic functions, and the carry chain is live. Subtraction adds the ones' complement of B. The carry output is therefore the inverse of a borrow.

Each slice also drives a group-propagate and a group-generate term that depend only on the operands and the select code, so an external lookahead unit can join slices. An all-ones flag reports when every result bit is high. The top module chains `SLICES` slices in ripple fashion: each slice's carry output feeds the next slice's carry input. With the default of four slices this forms a 16-bit ALU. The carry input and carry output are active-low, and so are the group terms.

Top module: `alu_ripple_chain`

## Requirements
- R1: With `logic_mode` high, each result bit is a function of the same-position A and B bits, chosen by `sel`: 0:~A 1:~(A|B) 2:~A&B 3:0 4:~(A&B) 5:~B 6:A^B 7:A&~B 8:~A|B 9:~(A^B) 10:B 11:A&B 12:1 13:A|~B 14:A|B 15:A.
- R2: With `logic_mode` low and no carry in, a slice computes the 4-bit sum L+R by `sel`: 0:A+0 1:(A|B)+0 2:(A|~B)+0 3:15+0 4:A+(A&~B) 5:(A|B)+(A&~B) 6:A+~B 7:(A&~B)+15 8:A+(A&B) 9:A+B 10:(A|~B)+(A&B) 11:(A&B)+15 12:A+A 13:(A|B)+A 14:(A|~B)+A 15:A+15. The slice's carry out is bit 4 of that sum.
- R3: The carry input is active-low. `carry_in_n` low adds one to the arithmetic result.
- R4: Code 6 in arithmetic mode gives A-B-1 with `carry_in_n` high and A-B with it low. `carry_out_n` high then signals a borrow (A<B when a carry is applied).
- R5: Code 9 in arithmetic mode is A+B. Code 12 is A+A, which moves every bit one place toward the MSB, with the old MSB going to the carry.
- R6: `eq_out` is high exactly when every bit of `f_out` is high. Under code 6 with no carry in, this flags A equal to B.
- R7: Slice k's `grp_prop_n[k]` is low iff every bit i of the slice has A_i=1, or (B_i=1 and sel[0]=1), or (B_i=0 and sel[1]=1). `grp_gen_n[k]` is low iff that slice's arithmetic sum without carry in overflows 4 bits. Neither term depends on `carry_in_n` or `logic_mode`.
- R8: `carry_out_n` is active-low (low = carry out) and is computed from the arithmetic function of `sel` whatever the value of `logic_mode`.
- R9: Across the chain, each slice's carry input is the carry output of the slice below it. The W-bit result therefore equals the wide-word arithmetic result, and the final carry equals the lookahead combination of the per-slice group terms.
- R10: With `logic_mode` high, `carry_in_n` has no effect on `f_out` or `eq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 4*SLICES | Operand A, active high |
| b_in | input | 4*SLICES | Operand B, active high |
| sel | input | 4 | Function select code |
| logic_mode | input | 1 | High: bitwise logic; low: arithmetic |
| carry_in_n | input | 1 | Carry into slice 0, active low |
| f_out | output | 4*SLICES | Result |
| carry_out_n | output | 1 | Carry out of the top slice, active low |
| eq_out | output | 1 | All result bits high |
| grp_prop_n | output | SLICES | Per-slice group propagate, active low |
| grp_gen_n | output | SLICES | Per-slice group generate, active low |

## Verification
The checker checks the following on every input change:
- The all-ones flag against the result.
- Exclusive-or in logic mode.
- Wide add and wide subtract, including the inverted borrow.
- Agreement between the final carry and a lookahead fold of the exported group terms.

The full 32-function table, the independence of the carry and group outputs from the mode bit and carry input, and the exhaustive bottom-slice sweep are shown only by the bench's scenarios. The bench sweeps every operand, select, mode and carry combination on the bottom slice, with random upper slices, and compares the results against table-driven expected values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int SLICE_W = 4;
    localparam int SEL_W   = 4;

    typedef logic [SLICE_W-1:0] nib_t;
    typedef logic [SEL_W-1:0]   sel_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_PASS_A   = 4'd0,
        SEL_SUB_DEC  = 4'd6,
        SEL_ADD      = 4'd9,
        SEL_DOUBLE   = 4'd12,
        SEL_DEC_A    = 4'd15
    } sel_named_e;

    typedef struct packed {
        sel_t sel;
        logic logic_mode;
    } op_ctl_t;

    typedef struct packed {
        nib_t prop;
        nib_t gen;
    } bit_terms_t;

    typedef struct packed {
        logic cout_n;
        logic eq;
        logic p_n;
        logic g_n;
    } slice_flags_t;

    // Per-bit operand selected onto the left adder input.
    function automatic logic bit_prop(input logic a, input logic b, input sel_t s);
        return a | (s[0] & b) | (s[1] & ~b);
    endfunction

    // Per-bit operand selected onto the right adder input; implies bit_prop.
    function automatic logic bit_gen(input logic a, input logic b, input sel_t s);
        return (s[3] & a & b) | (s[2] & a & ~b);
    endfunction

endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
    import alu_pkg::*;
(
    input  nib_t       a,
    input  nib_t       b,
    input  sel_t       sel,
    output bit_terms_t terms
);
    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        assign terms.prop[i] = bit_prop(a[i], b[i], sel);
        assign terms.gen[i]  = bit_gen(a[i], b[i], sel);
    end
endmodule

// File: rtl/alu_group_carry.sv
module alu_group_carry #(
    parameter int N = 4
) (
    input  logic [N-1:0] prop,
    input  logic [N-1:0] gen,
    input  logic         cin,
    output logic [N-1:0] carry,
    output logic         cout,
    output logic         grp_p,
    output logic         grp_g
);
    logic [N:0] c_full;
    logic [N:0] gen_only;
    logic [N:0] prop_run;

    // Two-level lookahead: each carry is an OR of generate terms ANDed with
    // the propagate terms above them, plus the full propagate run times cin.
    always_comb begin
        c_full   = '0;
        gen_only = '0;
        prop_run = '0;
        for (int i = 0; i <= N; i++) begin
            logic acc;
            logic run;
            acc = 1'b0;
            run = 1'b1;
            for (int j = 0; j < i; j++) begin
                logic term;
                term = gen[j];
                for (int k = j + 1; k < i; k++) begin
                    term = term & prop[k];
                end
                acc = acc | term;
                run = run & prop[j];
            end
            gen_only[i] = acc;
            prop_run[i] = run;
            c_full[i]   = acc | (run & cin);
        end
    end

    assign carry = c_full[N-1:0];
    assign cout  = c_full[N];
    assign grp_g = gen_only[N];
    assign grp_p = prop_run[N];
endmodule

// File: rtl/alu_slice4.sv
module alu_slice4
    import alu_pkg::*;
(
    input  nib_t         a,
    input  nib_t         b,
    input  op_ctl_t      ctl,
    input  logic         cin_n,
    output nib_t         f,
    output slice_flags_t flags
);
    bit_terms_t terms;
    nib_t       carry;
    logic       cout;
    logic       grp_p;
    logic       grp_g;
    nib_t       half;

    alu_bit_terms u_terms (
        .a     (a),
        .b     (b),
        .sel   (ctl.sel),
        .terms (terms)
    );

    alu_group_carry #(.N(SLICE_W)) u_carry (
        .prop  (terms.prop),
        .gen   (terms.gen),
        .cin   (~cin_n),
        .carry (carry),
        .cout  (cout),
        .grp_p (grp_p),
        .grp_g (grp_g)
    );

    for (genvar i = 0; i < SLICE_W; i++) begin : g_res
        assign half[i] = terms.prop[i] ^ terms.gen[i];
        // Logic mode: carries suppressed and the half-sum inverted.
        assign f[i] = ctl.logic_mode ? ~half[i] : (half[i] ^ carry[i]);
    end

    assign flags.cout_n = ~cout;
    assign flags.eq     = &f;
    assign flags.p_n    = ~grp_p;
    assign flags.g_n    = ~grp_g;
endmodule

// File: rtl/alu_ripple_chain.sv
module alu_ripple_chain
    import alu_pkg::*;
#(
    parameter int SLICES = 4,
    localparam int W = SLICES * SLICE_W
) (
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      b_in,
    input  logic [SEL_W-1:0]  sel,
    input  logic              logic_mode,
    input  logic              carry_in_n,
    output logic [W-1:0]      f_out,
    output logic              carry_out_n,
    output logic              eq_out,
    output logic [SLICES-1:0] grp_prop_n,
    output logic [SLICES-1:0] grp_gen_n
);
    op_ctl_t           ctl;
    logic [SLICES:0]   chain_n;
    logic [SLICES-1:0] slice_eq;

    assign ctl.sel        = sel;
    assign ctl.logic_mode = logic_mode;
    assign chain_n[0]     = carry_in_n;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        slice_flags_t fl;
        alu_slice4 u_slice (
            .a     (a_in[k*SLICE_W +: SLICE_W]),
            .b     (b_in[k*SLICE_W +: SLICE_W]),
            .ctl   (ctl),
            .cin_n (chain_n[k]),
            .f     (f_out[k*SLICE_W +: SLICE_W]),
            .flags (fl)
        );
        assign chain_n[k+1]  = fl.cout_n;
        assign slice_eq[k]   = fl.eq;
        assign grp_prop_n[k] = fl.p_n;
        assign grp_gen_n[k]  = fl.g_n;
    end

    assign carry_out_n = chain_n[SLICES];
    // Per-slice flags combine as a wired AND would.
    assign eq_out      = &slice_eq;
endmodule

// File: rtl/alu_chain_checker.sv
module alu_chain_checker #(
    parameter int SLICES = 4,
    localparam int W = SLICES * 4
) (
    input logic [W-1:0]      a_in,
    input logic [W-1:0]      b_in,
    input logic [3:0]        sel,
    input logic              logic_mode,
    input logic              carry_in_n,
    input logic [W-1:0]      f_out,
    input logic              carry_out_n,
    input logic              eq_out,
    input logic [SLICES-1:0] grp_prop_n,
    input logic [SLICES-1:0] grp_gen_n
);
    logic [W:0] wide_add;
    logic [W:0] wide_sub;
    logic       folded_c;

    always_comb begin
        wide_add = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, ~carry_in_n};
        wide_sub = {1'b0, a_in} + {1'b0, ~b_in} + {{W{1'b0}}, ~carry_in_n};
        folded_c = ~carry_in_n;
        for (int k = 0; k < SLICES; k++) begin
            folded_c = ~grp_gen_n[k] | (~grp_prop_n[k] & folded_c);
        end
    end

    always_comb begin
        assert_eq_all_ones_R6: assert (eq_out == (&f_out));
        if (logic_mode && sel == 4'd6) begin
            assert_logic_xor_R1: assert (f_out == (a_in ^ b_in));
        end
        if (!logic_mode && sel == 4'd9) begin
            assert_wide_add_R5: assert ({~carry_out_n, f_out} == wide_add);
        end
        if (!logic_mode && sel == 4'd6) begin
            assert_wide_sub_borrow_R4: assert ({~carry_out_n, f_out} == wide_sub);
        end
        assert_lookahead_fold_R9: assert (carry_out_n == ~folded_c);
    end
endmodule

bind alu_ripple_chain alu_chain_checker #(.SLICES(SLICES)) u_chain_chk (
    .a_in        (a_in),
    .b_in        (b_in),
    .sel         (sel),
    .logic_mode  (logic_mode),
    .carry_in_n  (carry_in_n),
    .f_out       (f_out),
    .carry_out_n (carry_out_n),
    .eq_out      (eq_out),
    .grp_prop_n  (grp_prop_n),
    .grp_gen_n   (grp_gen_n)
);

// File: tb/alu_ripple_chain_test.sv
`timescale 1ns/1ps
module alu_ripple_chain_test;
    localparam int SLICES = 4;
    localparam int W      = SLICES * 4;
    localparam int OW     = W + 2 + 2 * SLICES;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [W-1:0]      a_in = '0;
    logic [W-1:0]      b_in = '0;
    logic [3:0]        sel = '0;
    logic              logic_mode = 1'b0;
    logic              carry_in_n = 1'b1;
    logic [W-1:0]      f_out;
    logic              carry_out_n;
    logic              eq_out;
    logic [SLICES-1:0] grp_prop_n;
    logic [SLICES-1:0] grp_gen_n;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    alu_ripple_chain #(.SLICES(SLICES)) uut (
        .a_in (a_in), .b_in (b_in), .sel (sel), .logic_mode (logic_mode),
        .carry_in_n (carry_in_n), .f_out (f_out), .carry_out_n (carry_out_n),
        .eq_out (eq_out), .grp_prop_n (grp_prop_n), .grp_gen_n (grp_gen_n)
    );

    // R2 operand pair by select code; sum of the two is the arithmetic result.
    function automatic logic [4:0] arith_sum(input logic [3:0] a, input logic [3:0] b,
                                             input logic [3:0] s, input logic cin);
        logic [3:0] l, r;
        case (s)
            4'd0:  begin l = a;        r = 4'd0;     end
            4'd1:  begin l = a | b;    r = 4'd0;     end
            4'd2:  begin l = a | ~b;   r = 4'd0;     end
            4'd3:  begin l = 4'd15;    r = 4'd0;     end
            4'd4:  begin l = a;        r = a & ~b;   end
            4'd5:  begin l = a | b;    r = a & ~b;   end
            4'd6:  begin l = a;        r = ~b;       end
            4'd7:  begin l = a & ~b;   r = 4'd15;    end
            4'd8:  begin l = a;        r = a & b;    end
            4'd9:  begin l = a;        r = b;        end
            4'd10: begin l = a | ~b;   r = a & b;    end
            4'd11: begin l = a & b;    r = 4'd15;    end
            4'd12: begin l = a;        r = a;        end
            4'd13: begin l = a | b;    r = a;        end
            4'd14: begin l = a | ~b;   r = a;        end
            default: begin l = a;      r = 4'd15;    end
        endcase
        return {1'b0, l} + {1'b0, r} + {4'd0, cin};
    endfunction

    // R1 logic table.
    function automatic logic [3:0] logic_res(input logic [3:0] a, input logic [3:0] b,
                                             input logic [3:0] s);
        case (s)
            4'd0:  return ~a;
            4'd1:  return ~(a | b);
            4'd2:  return ~a & b;
            4'd3:  return 4'h0;
            4'd4:  return ~(a & b);
            4'd5:  return ~b;
            4'd6:  return a ^ b;
            4'd7:  return a & ~b;
            4'd8:  return ~a | b;
            4'd9:  return ~(a ^ b);
            4'd10: return b;
            4'd11: return a & b;
            4'd12: return 4'hF;
            4'd13: return a | ~b;
            4'd14: return a | b;
            default: return a;
        endcase
    endfunction

    // Expected {f, cout_n, eq, p_n, g_n} for the whole chain (R1..R10).
    function automatic logic [OW-1:0] ref_chain(input logic [W-1:0] a, input logic [W-1:0] b,
                                                input logic [3:0] s, input logic m,
                                                input logic cin_n);
        logic [W-1:0]      f;
        logic [SLICES-1:0] pn, gn;
        logic              c;
        c = ~cin_n;
        for (int k = 0; k < SLICES; k++) begin
            logic [3:0] an, bn;
            logic [4:0] sm, sm0;
            logic       pall;
            an  = a[k*4 +: 4];
            bn  = b[k*4 +: 4];
            sm  = arith_sum(an, bn, s, c);
            sm0 = arith_sum(an, bn, s, 1'b0);
            f[k*4 +: 4] = m ? logic_res(an, bn, s) : sm[3:0];
            pall = 1'b1;
            for (int i = 0; i < 4; i++) begin
                pall = pall & (an[i] | (bn[i] & s[0]) | (~bn[i] & s[1]));
            end
            pn[k] = ~pall;
            gn[k] = ~sm0[4];
            c     = sm[4];
        end
        return {f, ~c, &f, pn, gn};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s a=%h b=%h sel=%0d m=%0b cin_n=%0b actual=%h expected=%h",
                     tag, a_in, b_in, sel, logic_mode, carry_in_n, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] s,
                         input logic m, input logic cn);
        @(negedge clk);
        a_in = a; b_in = b; sel = s; logic_mode = m; carry_in_n = cn;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [OW-1:0] observed();
        return {f_out, carry_out_n, eq_out, grp_prop_n, grp_gen_n};
    endfunction

    task automatic drive_and_compare(input string tag, input logic [W-1:0] a,
                                     input logic [W-1:0] b, input logic [3:0] s,
                                     input logic m, input logic cn);
        drive(a, b, s, m, cn);
        check(tag, 64'(observed()), 64'(ref_chain(a, b, s, m, cn)));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] hold_f;
        logic [SLICES*2-1:0] hold_pg;
        logic hold_c, hold_eq;
        void'($urandom(32'h5A17_C0DE));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: zero operands, pass-A, no carry.
        drive('0, '0, 4'd0, 1'b0, 1'b1);
        check("R2 idle f",    64'(f_out), 64'h0);
        check("R8 idle cout", 64'(carry_out_n), 64'h1);
        check("R6 idle eq",   64'(eq_out), 64'h0);

        // Exhaustive bottom slice, random upper slices (R1 logic, R2 arithmetic).
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 2; m++) begin
                for (int cn = 0; cn < 2; cn++) begin
                    for (int ab = 0; ab < 256; ab++) begin
                        logic [W-1:0] ra, rb;
                        ra = W'($urandom);
                        rb = W'($urandom);
                        ra[3:0] = 4'(ab);
                        rb[3:0] = 4'(ab >> 4);
                        drive_and_compare(m ? "R1 sweep" : "R2 sweep", ra, rb,
                                          4'(s), 1'(m), 1'(cn));
                    end
                end
            end
        end

        // Random full-width mix (R9 chain).
        for (int n = 0; n < 2000; n++) begin
            drive_and_compare("R9 random", W'($urandom), W'($urandom), 4'($urandom),
                              1'($urandom), 1'($urandom));
        end

        // R3: carry-in adds one.
        drive(16'h00FF, 16'h0000, 4'd0, 1'b0, 1'b0);
        check("R3 inc f",    64'(f_out), 64'h0100);
        check("R3 inc cout", 64'(carry_out_n), 64'h1);

        // R4: subtract with borrow.
        drive(16'h0005, 16'h0009, 4'd6, 1'b0, 1'b0);
        check("R4 sub f",      64'(f_out), 64'hFFFC);
        check("R4 borrow",     64'(carry_out_n), 64'h1);
        drive(16'h0009, 16'h0005, 4'd6, 1'b0, 1'b0);
        check("R4 sub f2",     64'(f_out), 64'h0004);
        check("R4 no borrow",  64'(carry_out_n), 64'h0);
        drive(16'h0009, 16'h0005, 4'd6, 1'b0, 1'b1);
        check("R4 sub minus1", 64'(f_out), 64'h0003);

        // R5: add and double.
        drive(16'hFFFF, 16'h0001, 4'd9, 1'b0, 1'b1);
        check("R5 add wrap f",    64'(f_out), 64'h0000);
        check("R5 add wrap cout", 64'(carry_out_n), 64'h0);
        drive(16'h8421, 16'h1357, 4'd12, 1'b0, 1'b1);
        check("R5 double f",    64'(f_out), 64'h0842);
        check("R5 double cout", 64'(carry_out_n), 64'h0);

        // R6: equality under subtract without carry.
        drive(16'hBEEF, 16'hBEEF, 4'd6, 1'b0, 1'b1);
        check("R6 equal eq", 64'(eq_out), 64'h1);
        check("R6 equal f",  64'(f_out), 64'hFFFF);
        drive(16'hBEEF, 16'hBEEE, 4'd6, 1'b0, 1'b1);
        check("R6 unequal eq", 64'(eq_out), 64'h0);

        // R7: group terms ignore carry-in and mode.
        drive(16'h3C5A, 16'h9E21, 4'd9, 1'b0, 1'b1);
        hold_pg = {grp_prop_n, grp_gen_n};
        drive(16'h3C5A, 16'h9E21, 4'd9, 1'b0, 1'b0);
        check("R7 pg vs cin", 64'({grp_prop_n, grp_gen_n}), 64'(hold_pg));
        drive(16'h3C5A, 16'h9E21, 4'd9, 1'b1, 1'b1);
        check("R7 pg vs mode", 64'({grp_prop_n, grp_gen_n}), 64'(hold_pg));

        // R8: carry out ignores mode.
        drive(16'hF0F0, 16'h1F1F, 4'd9, 1'b0, 1'b1);
        hold_c = carry_out_n;
        drive(16'hF0F0, 16'h1F1F, 4'd9, 1'b1, 1'b1);
        check("R8 cout vs mode", 64'(carry_out_n), 64'(hold_c));
        check("R8 cout value",   64'(carry_out_n), 64'h0);

        // R10: carry-in ignored in logic mode.
        drive(16'hA5C3, 16'h0FF0, 4'd6, 1'b1, 1'b1);
        hold_f  = f_out;
        hold_eq = eq_out;
        drive(16'hA5C3, 16'h0FF0, 4'd6, 1'b1, 1'b0);
        check("R10 f vs cin",  64'(f_out), 64'(hold_f));
        check("R10 eq vs cin", 64'(eq_out), 64'(hold_eq));
        check("R10 f value",   64'(f_out), 64'hAA33);

        // R9: carry ripples across every slice boundary.
        drive(16'h0FFF, 16'h0000, 4'd0, 1'b0, 1'b0);
        check("R9 ripple f", 64'(f_out), 64'h1000);
        drive(16'hFFFF, 16'h0000, 4'd0, 1'b0, 1'b0);
        check("R9 ripple all", 64'({carry_out_n, f_out}), 64'h0_0000);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule